// File: doc/BRIEF.md
# Video Pixel Serializer with Colour Palette

This block turns display memory bytes into a stream of RGB logic-level pixels. When a memory access slot ends, a new display byte is captured. After that, one pixel leaves the byte on each pixel-clock enable. The display depth setting decides how many bits of the byte form one pixel: one bit gives eight pixels per byte, two bits give four, and four bits give two. Multi-bit pixels take their bits from positions spread evenly across the byte, so the byte only ever shifts left by one place per pixel, whatever the depth.

Each pixel's value is a logical colour. That colour indexes a sixteen-entry programmable palette. Each palette entry holds a physical red/green/blue triple and a flash flag. When the flash phase input is high, an entry with its flag set is output inverted. Reprogramming the palette changes what appears on screen but never alters the captured byte. The outputs are forced to black while the display-enable input is low. The host drives the palette write port, the depth setting and the flash phase. A memory sequencer drives the load strobe and the pixel clock enable.

Top module: `vid_pixel_serializer`

## Requirements
- R1: After reset, red, green and blue are low, the pixel shift register is empty (all zero), and palette entry i holds flash=0 with RGB equal to the low three bits of i.
- R2: A high `byte_load` at a clock edge captures `ram_byte` into the shift register. If `pix_en` is also high at that edge, the pixel emitted is taken from the old contents and the new byte is not shifted.
- R3: Each clock edge with `pix_en` high registers exactly one pixel onto the outputs and shifts the register left by one, filling with zero. The outputs do not change at edges with `pix_en` low.
- R4: With `depth` = 0, the logical colour is the single bit in shift register bit 7, giving eight pixels per byte.
- R5: With `depth` = 1, the logical colour is {bit 7, bit 3} of the shift register (bit 7 most significant), giving four pixels per byte.
- R6: With `depth` = 2 or 3, the logical colour is {bit 7, bit 5, bit 3, bit 1} of the shift register, giving two pixels per byte.
- R7: A high `pal_we` writes `pal_data` into entry `pal_addr`. In `pal_data`, bit 3 is the flash flag, bit 2 is red, bit 1 is green and bit 0 is blue. A displayed pixel shows that entry's RGB on red/green/blue.
- R8: When an entry's flash flag is set and `flash_phase` is high, its RGB is output bit-inverted. An entry with a clear flag is unaffected by `flash_phase`.
- R9: A pixel emitted while `disp_en` is low is black, whatever its logical colour.
- R10: A palette write at the same edge as a pixel leaves that pixel with the old entry value. The next pixel uses the new value, and the captured byte is left unchanged.
- R11: Once all bits of a byte have been shifted out, further pixels take logical colour 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_load | input | 1 | End of memory access slot: capture ram_byte |
| pix_en | input | 1 | Pixel clock enable: emit one pixel |
| ram_byte | input | 8 | Display byte from memory |
| disp_en | input | 1 | Display active; low forces black |
| depth | input | 2 | Bits per pixel: 0 one, 1 two, 2/3 four |
| flash_phase | input | 1 | Flash phase; high inverts flashing colours |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 4 | Palette entry (logical colour) to write |
| pal_data | input | 4 | {flash, red, green, blue} |
| red | output | 1 | Red logic output |
| green | output | 1 | Green logic output |
| blue | output | 1 | Blue logic output |

## Verification
- A load reaches the shift register one edge after `byte_load` is seen.
- Each pixel reaches red/green/blue at the same edge that samples `pix_en`, so the pixel selected by the byte's k-th shift appears k+1 enabled edges after the load.
- Palette writes act at their own edge. They are therefore visible to the first pixel registered after that edge, and not to a pixel registered at that same edge.
- The bench changes inputs on the falling edge, lets exactly one rising edge pass per load, write or pixel, and reads the outputs on the next falling edge. It compares them against a bench-side palette model and a bit-extraction model written from the requirements.

// File: rtl/vid_ser_pkg.sv
package vid_ser_pkg;

  localparam int RGB_W = 3;

  typedef struct packed {
    logic             flash;
    logic [RGB_W-1:0] rgb;
  } pal_entry_t;

  typedef enum logic [1:0] {
    DEPTH_1 = 2'd0,
    DEPTH_2 = 2'd1,
    DEPTH_4 = 2'd2,
    DEPTH_4_ALT = 2'd3
  } depth_e;

endpackage

// File: rtl/pixel_shifter.sv
module pixel_shifter
  import vid_ser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] din,
  input  depth_e            depth,
  output logic [DATA_W-1:0] shreg,
  output logic [IDX_W-1:0]  colour
);

  localparam int HALF   = IDX_W / 2;
  localparam int STR_HI = DATA_W / IDX_W;
  localparam int STR_MD = DATA_W / HALF;

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_one, idx_two, idx_four;

  always_comb begin
    sh_d = sh_q;
    if (load)      sh_d = din;
    else if (step) sh_d = {sh_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // one bit per pixel: the head bit only
  assign idx_one = {{(IDX_W-1){1'b0}}, sh_q[DATA_W-1]};

  // two bits per pixel: bits spaced DATA_W/2 apart
  genvar k;
  generate
    for (k = 0; k < HALF; k++) begin : g_two
      assign idx_two[HALF-1-k] = sh_q[DATA_W-1-k*STR_MD];
    end
    assign idx_two[IDX_W-1:HALF] = '0;

    // four bits per pixel: bits spaced DATA_W/4 apart
    for (k = 0; k < IDX_W; k++) begin : g_four
      assign idx_four[IDX_W-1-k] = sh_q[DATA_W-1-k*STR_HI];
    end
  endgenerate

  always_comb begin
    case (depth)
      DEPTH_1: colour = idx_one;
      DEPTH_2: colour = idx_two;
      default: colour = idx_four;
    endcase
  end

  assign shreg = sh_q;

endmodule

// File: rtl/colour_palette.sv
module colour_palette
  import vid_ser_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  pal_entry_t       wdata,
  input  logic [IDX_W-1:0] raddr,
  output pal_entry_t       rdata
);

  localparam int ENTRIES = 1 << IDX_W;

  pal_entry_t mem_q [ENTRIES];
  pal_entry_t mem_d [ENTRIES];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) mem_d[i] = mem_q[i];
    if (we) mem_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        mem_q[i].flash <= 1'b0;
        mem_q[i].rgb   <= RGB_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/vid_pixel_serializer.sv
module vid_pixel_serializer
  import vid_ser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_load,
  input  logic              pix_en,
  input  logic [DATA_W-1:0] ram_byte,
  input  logic              disp_en,
  input  logic [1:0]        depth,
  input  logic              flash_phase,
  input  logic              pal_we,
  input  logic [IDX_W-1:0]  pal_addr,
  input  logic [IDX_W-1:0]  pal_data,
  output logic              red,
  output logic              green,
  output logic              blue
);

  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  colour;
  pal_entry_t        entry;
  logic [RGB_W-1:0]  rgb_q, rgb_d, shown;

  pixel_shifter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (byte_load),
    .step   (pix_en),
    .din    (ram_byte),
    .depth  (depth_e'(depth)),
    .shreg  (shreg),
    .colour (colour)
  );

  colour_palette #(.IDX_W(IDX_W)) i_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_entry_t'(pal_data[RGB_W:0])),
    .raddr (colour),
    .rdata (entry)
  );

  assign shown = entry.rgb ^ {RGB_W{entry.flash & flash_phase}};

  always_comb begin
    rgb_d = rgb_q;
    if (pix_en) rgb_d = disp_en ? shown : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_q <= '0;
    else        rgb_q <= rgb_d;
  end

  assign red   = rgb_q[2];
  assign green = rgb_q[1];
  assign blue  = rgb_q[0];

endmodule

// File: rtl/vid_ser_chk.sv
module vid_ser_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_load,
  input logic              pix_en,
  input logic              disp_en,
  input logic [DATA_W-1:0] ram_byte,
  input logic [DATA_W-1:0] shreg,
  input logic [2:0]        rgb
);

  // R9
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !disp_en) |=> (rgb == 3'b000));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(rgb));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load |=> (shreg == $past(ram_byte)));

  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !byte_load) |=> (shreg == {$past(shreg[DATA_W-2:0]), 1'b0}));

  // R10
  byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !byte_load) |=> $stable(shreg));

endmodule

bind vid_pixel_serializer vid_ser_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_load (byte_load),
  .pix_en    (pix_en),
  .disp_en   (disp_en),
  .ram_byte  (ram_byte),
  .shreg     (shreg),
  .rgb       ({red, green, blue})
);

// File: tb/test_vid_pixel_serializer.sv
module test_vid_pixel_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_load = 1'b0;
  logic       pix_en = 1'b0;
  logic [7:0] ram_byte = '0;
  logic       disp_en = 1'b1;
  logic [1:0] depth = 2'd0;
  logic       flash_phase = 1'b0;
  logic       pal_we = 1'b0;
  logic [3:0] pal_addr = '0;
  logic [3:0] pal_data = '0;
  logic       red, green, blue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [3:0] pal_m [16];

  always #10 clk = ~clk;

  vid_pixel_serializer i_vid_pixel_serializer (
    .clk(clk), .rst_n(rst_n), .byte_load(byte_load), .pix_en(pix_en),
    .ram_byte(ram_byte), .disp_en(disp_en), .depth(depth),
    .flash_phase(flash_phase), .pal_we(pal_we), .pal_addr(pal_addr),
    .pal_data(pal_data), .red(red), .green(green), .blue(blue)
  );

  function automatic logic [3:0] exp_idx(input logic [7:0] b, input logic [1:0] m, input int p);
    logic [7:0] s;
    s = b << p;
    case (m)
      2'd0:    return {3'b000, s[7]};
      2'd1:    return {2'b00, s[7], s[3]};
      default: return {s[7], s[5], s[3], s[1]};
    endcase
  endfunction

  function automatic logic [2:0] exp_rgb(input logic [3:0] idx);
    if (!disp_en) return 3'b000;
    return pal_m[idx][2:0] ^ {3{pal_m[idx][3] & flash_phase}};
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {red, green, blue};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: rgb=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] b);
    byte_load = 1'b1; ram_byte = b;
    @(negedge clk);
    byte_load = 1'b0;
  endtask

  task automatic do_pix();
    pix_en = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  task automatic do_pal(input logic [3:0] a, input logic [3:0] d);
    pal_we = 1'b1; pal_addr = a; pal_data = d;
    @(negedge clk);
    pal_we = 1'b0;
    pal_m[a] = d;
  endtask

  task automatic run_byte(input string req, input logic [7:0] b, input logic [1:0] m, input int n);
    depth = m;
    do_load(b);
    for (int p = 0; p < n; p++) begin
      do_pix();
      check(req, exp_rgb(exp_idx(b, m, p)));
    end
  endtask

  task automatic t_reset();
    check("R1 reset outputs", 3'b000);
    disp_en = 1'b1; depth = 2'd0;
    do_pix();
    check("R1 empty shifter", exp_rgb(4'd0));
    run_byte("R1 reset entry 1", 8'hFF, 2'd0, 1);
    check("R1 entry 1 value", 3'b001);
    run_byte("R1 reset entry 15", 8'hFF, 2'd2, 1);
    check("R1 entry 15 value", 3'b111);
  endtask

  task automatic t_depth1();
    do_pal(4'd0, 4'b0010);
    do_pal(4'd1, 4'b0101);
    run_byte("R4 R7 one bit per pixel", 8'hA5, 2'd0, 8);
  endtask

  task automatic t_depth2();
    do_pal(4'd0, 4'b0001);
    do_pal(4'd1, 4'b0110);
    do_pal(4'd2, 4'b0011);
    do_pal(4'd3, 4'b0100);
    run_byte("R5 two bits per pixel", 8'h6C, 2'd1, 4);
    run_byte("R5 two bits pattern b", 8'hC3, 2'd1, 4);
  endtask

  task automatic t_depth4();
    for (int i = 0; i < 16; i++) do_pal(4'(i), 4'(7 - (i % 8)));
    run_byte("R6 four bits depth 2", 8'h9E, 2'd2, 2);
    run_byte("R6 four bits depth 3", 8'h5B, 2'd3, 2);
  endtask

  task automatic t_hold_exhaust();
    do_pal(4'd0, 4'b0100);
    do_pal(4'd1, 4'b0011);
    run_byte("R11 byte drains", 8'h01, 2'd0, 8);
    repeat (3) @(negedge clk);
    check("R3 hold without pix_en", 3'b011);
    do_pix();
    check("R11 zero after drain", 3'b100);
    do_pix();
    check("R11 zero after drain 2", 3'b100);
  endtask

  task automatic t_flash();
    do_pal(4'd1, 4'b1110);
    do_pal(4'd0, 4'b0010);
    flash_phase = 1'b0;
    run_byte("R8 flash off phase", 8'h80, 2'd0, 2);
    flash_phase = 1'b1;
    run_byte("R8 flash on phase", 8'h80, 2'd0, 2);
    check("R8 steady entry under phase", 3'b010);
    flash_phase = 1'b0;
  endtask

  task automatic t_blank();
    do_pal(4'd1, 4'b0111);
    disp_en = 1'b0;
    run_byte("R9 blanked", 8'hFF, 2'd0, 2);
    check("R9 black", 3'b000);
    disp_en = 1'b1;
    do_pix();
    check("R9 display resumes", 3'b111);
  endtask

  task automatic t_collision();
    do_pal(4'd1, 4'b0001);
    depth = 2'd0;
    do_load(8'hFF);
    pix_en = 1'b1; pal_we = 1'b1; pal_addr = 4'd1; pal_data = 4'b0110;
    @(negedge clk);
    pix_en = 1'b0; pal_we = 1'b0;
    check("R10 pixel keeps old entry", 3'b001);
    pal_m[1] = 4'b0110;
    do_pix();
    check("R10 next pixel new entry", 3'b110);
    do_pix();
    check("R10 byte unchanged by write", 3'b110);
  endtask

  task automatic t_priority();
    do_pal(4'd0, 4'b0011);
    do_pal(4'd1, 4'b0101);
    depth = 2'd0;
    do_load(8'h80);
    byte_load = 1'b1; ram_byte = 8'h7F; pix_en = 1'b1;
    @(negedge clk);
    byte_load = 1'b0; pix_en = 1'b0;
    check("R2 pixel from old byte", 3'b101);
    do_pix();
    check("R2 new byte head unshifted", 3'b011);
    do_pix();
    check("R2 new byte second", 3'b101);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pal_m[i] = {1'b0, 3'(i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_depth1();
    t_depth2();
    t_depth4();
    t_hold_exhaust();
    t_flash();
    t_blank();
    t_collision();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule